// File: doc/BRIEF.md
# Micro-frame Index and Frame Number Shadow

This block holds the running micro-frame index of a USB 2.0 host controller and an 11-bit frame number shadow that supplies the value placed in each start-of-frame token. The index moves forward by one on every micro-frame tick while the controller is running. The shadow moves forward once every eight micro-frames.

From the index the block forms the byte address of the current entry in a 1024-entry periodic frame list. Each list entry stays selected for eight consecutive micro-frames.

Software sees the index through a 32-bit register. It may write that register only while the controller is halted. A write also reloads the shadow from the upper index bits, so the two counters stay consistent.

Top module: `mfi_frame_index`

## Requirements
- R1: After reset, the index, the shadow and the read data are all zero.
- R2: `reg_rdata` carries the 14-bit index in bits 13:0. Bits 31:14 always read as zero.
- R3: The index increments by one on a clock edge where `uf_tick`, `run_i` and `!halted_i` are all high. At any other edge, with no accepted write, the index and the shadow hold their values.
- R4: `list_addr_o` equals `list_base_i + (index[12:3] * 4)`, so each list entry is used for 8 consecutive micro-frames.
- R5: The shadow increments by one on an advance whose index bits 2:0 go from 000 to 001, and on no other advance.
- R6: A write is accepted when `reg_wr_en` is high, `reg_wr_strb` is 4'b1111 and `halted_i` is high. It loads the index with `reg_wdata[13:0]` and the shadow with `reg_wdata[13:3]`. Bits 31:14 of the write data are discarded.
- R7: A write while `halted_i` is low is ignored, and both counters keep their values.
- R8: A write with any strobe other than 4'b1111 is ignored.
- R9: A write whose low three bits are 111 or 000 is loaded unchanged. After a 111 load the next advance does not step the shadow. After a 000 load the next advance does step it.
- R10: The index wraps from 0x3FFF to 0x0000 and the shadow wraps from 0x7FF to 0x000, with no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uf_tick | input | 1 | One-cycle pulse at the end of each micro-frame |
| run_i | input | 1 | Controller run control |
| halted_i | input | 1 | Controller halted status |
| reg_wr_en | input | 1 | Register write request |
| reg_wr_strb | input | 4 | Byte-lane strobes of the write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| list_base_i | input | 32 | 4 KB-aligned base of the periodic frame list |
| idx_o | output | 14 | Current micro-frame index |
| sof_o | output | 11 | Frame number shadow for the start-of-frame token |
| list_addr_o | output | 32 | Byte address of the current frame-list entry |

## Verification
The bench builds the block with its default parameters: a 14-bit index, an 11-bit shadow, a 10-bit list selector and 32-bit addresses. These are the widths the register layout fixes.

With these widths, a single register write can place the index just below 0x3FFF, so a handful of ticks reaches both wrap points. The same writes can set up the awkward 111 and 000 low-bit loads and show how the shadow answers on the next tick. A non-zero list base shows that the entry address is an offset from the base, and that the selector changes only every eighth micro-frame.

// File: rtl/mfi_pkg.sv
package mfi_pkg;
  localparam int REG_W  = 32;
  localparam int STRB_W = REG_W / 8;

  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_STEP = 2'd1,
    CNT_LOAD = 2'd2
  } cnt_op_e;
endpackage

// File: rtl/mfi_reg_port.sv
module mfi_reg_port
  import mfi_pkg::*;
#(
  parameter int IDX_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              uf_tick,
  input  logic              run_i,
  input  logic              halted_i,
  input  logic              reg_wr_en,
  input  logic [STRB_W-1:0] reg_wr_strb,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic [IDX_W-1:0]  idx_cur,
  output cnt_op_e           cnt_op,
  output logic [IDX_W-1:0]  load_val,
  output logic [REG_W-1:0]  reg_rdata
);
  localparam int PAD_W = REG_W - IDX_W;

  logic wr_ok;
  logic adv_ok;
  logic unused_hi;

  // A write counts only with every byte lane set, and only while halted.
  assign wr_ok     = reg_wr_en && (&reg_wr_strb) && halted_i;
  assign adv_ok    = uf_tick && run_i && !halted_i;
  assign load_val  = reg_wdata[IDX_W-1:0];
  assign unused_hi = ^reg_wdata[REG_W-1:IDX_W];
  assign reg_rdata = {{PAD_W{1'b0}}, idx_cur};

  always_comb begin
    cnt_op = CNT_HOLD;
    if (wr_ok)       cnt_op = CNT_LOAD;
    else if (adv_ok) cnt_op = CNT_STEP;
  end

  // R7: the counters can never be loaded while the controller is running
  a_r7_no_load_running: assert property (@(posedge clk) disable iff (!rst_n)
    !halted_i |-> cnt_op != CNT_LOAD);
  // R8: a partial-strobe request never loads the counters
  a_r8_partial_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_strb != {STRB_W{1'b1}}) |-> cnt_op != CNT_LOAD);
endmodule

// File: rtl/mfi_index_ctr.sv
module mfi_index_ctr
  import mfi_pkg::*;
#(
  parameter int IDX_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cnt_op_e          cnt_op,
  input  logic [IDX_W-1:0] load_val,
  output logic [IDX_W-1:0] idx_q
);
  logic [IDX_W-1:0] idx_d;
  logic             idx_en;

  always_comb begin
    idx_d  = idx_q;
    idx_en = 1'b0;
    case (cnt_op)
      CNT_STEP: begin idx_d = idx_q + 1'b1; idx_en = 1'b1; end
      CNT_LOAD: begin idx_d = load_val;     idx_en = 1'b1; end
      default:  begin idx_d = idx_q;        idx_en = 1'b0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  // R3: an advance moves the index forward by exactly one (wrap included, R10)
  a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_op == CNT_STEP |=> idx_q == $past(idx_q) + 1'b1);
  // R3: no advance and no write means the index holds
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_op == CNT_HOLD |=> $stable(idx_q));
  // R6: an accepted write lands in the index on the next cycle
  a_r6_load_idx: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_op == CNT_LOAD |=> idx_q == $past(load_val));
endmodule

// File: rtl/mfi_sof_shadow.sv
module mfi_sof_shadow
  import mfi_pkg::*;
#(
  parameter int IDX_W = 14,
  parameter int SOF_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cnt_op_e          cnt_op,
  input  logic [IDX_W-1:0] load_val,
  input  logic [IDX_W-1:0] idx_cur,
  output logic [SOF_W-1:0] sof_q
);
  localparam int SUB_W = IDX_W - SOF_W;

  logic [SOF_W-1:0] sof_d;
  logic             sof_en;
  logic             at_first_uf;

  // The index is sitting at sub-frame 0, so the next step goes to 1.
  assign at_first_uf = (idx_cur[SUB_W-1:0] == '0);

  always_comb begin
    sof_d  = sof_q;
    sof_en = 1'b0;
    if (cnt_op == CNT_LOAD) begin
      sof_d  = load_val[IDX_W-1:SUB_W];
      sof_en = 1'b1;
    end else if (cnt_op == CNT_STEP && at_first_uf) begin
      sof_d  = sof_q + 1'b1;
      sof_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sof_q <= '0;
    else if (sof_en) sof_q <= sof_d;
  end

  // R5: a step that starts from any other sub-frame leaves the shadow alone
  a_r5_no_step_mid: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_op == CNT_STEP && !at_first_uf) |=> $stable(sof_q));
  // R5: leaving sub-frame 0 advances the shadow by one (wrap included, R10)
  a_r5_step_on_one: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_op == CNT_STEP && at_first_uf) |=> sof_q == $past(sof_q) + 1'b1);
  // R6: a write reloads the shadow from the upper written bits
  a_r6_load_sof: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_op == CNT_LOAD |=> sof_q == $past(load_val[IDX_W-1:SUB_W]));
endmodule

// File: rtl/mfi_list_addr.sv
module mfi_list_addr #(
  parameter int ADDR_W = 32,
  parameter int LIST_W = 10
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [LIST_W-1:0] entry_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int OFF_W = LIST_W + 2;

  logic [OFF_W-1:0] byte_off;

  assign byte_off = {entry_i, 2'b00};
  assign addr_o   = base_i + {{(ADDR_W-OFF_W){1'b0}}, byte_off};
endmodule

// File: rtl/mfi_frame_index.sv
module mfi_frame_index
  import mfi_pkg::*;
#(
  parameter int IDX_W  = 14,
  parameter int SOF_W  = 11,
  parameter int LIST_W = 10,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              uf_tick,
  input  logic              run_i,
  input  logic              halted_i,
  input  logic              reg_wr_en,
  input  logic [STRB_W-1:0] reg_wr_strb,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [ADDR_W-1:0] list_base_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [SOF_W-1:0]  sof_o,
  output logic [ADDR_W-1:0] list_addr_o
);
  localparam int SUB_W = IDX_W - SOF_W;

  cnt_op_e          cnt_op;
  logic [IDX_W-1:0] load_val;
  logic [IDX_W-1:0] idx_q;
  logic [SOF_W-1:0] sof_q;

  mfi_reg_port #(.IDX_W(IDX_W)) u_port (
    .clk(clk), .rst_n(rst_n), .uf_tick(uf_tick), .run_i(run_i),
    .halted_i(halted_i), .reg_wr_en(reg_wr_en), .reg_wr_strb(reg_wr_strb),
    .reg_wdata(reg_wdata), .idx_cur(idx_q), .cnt_op(cnt_op),
    .load_val(load_val), .reg_rdata(reg_rdata)
  );

  mfi_index_ctr #(.IDX_W(IDX_W)) u_idx (
    .clk(clk), .rst_n(rst_n), .cnt_op(cnt_op), .load_val(load_val),
    .idx_q(idx_q)
  );

  mfi_sof_shadow #(.IDX_W(IDX_W), .SOF_W(SOF_W)) u_sof (
    .clk(clk), .rst_n(rst_n), .cnt_op(cnt_op), .load_val(load_val),
    .idx_cur(idx_q), .sof_q(sof_q)
  );

  mfi_list_addr #(.ADDR_W(ADDR_W), .LIST_W(LIST_W)) u_addr (
    .base_i(list_base_i), .entry_i(idx_q[SUB_W+LIST_W-1:SUB_W]),
    .addr_o(list_addr_o)
  );

  assign idx_o = idx_q;
  assign sof_o = sof_q;

  // R2: the reserved upper read bits stay zero
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[REG_W-1:IDX_W] == '0);
endmodule

// File: tb/mfi_frame_index_bench.sv
module mfi_frame_index_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        uf_tick = 1'b0;
  logic        run_i = 1'b0;
  logic        halted_i = 1'b1;
  logic        reg_wr_en = 1'b0;
  logic [3:0]  reg_wr_strb = 4'h0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] list_base_i = 32'h0003_A000;
  logic [13:0] idx_o;
  logic [10:0] sof_o;
  logic [31:0] list_addr_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [13:0] exp_idx = '0;
  logic [10:0] exp_sof = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mfi_frame_index u_mfi_frame_index (
    .clk(clk), .rst_n(rst_n), .uf_tick(uf_tick), .run_i(run_i),
    .halted_i(halted_i), .reg_wr_en(reg_wr_en), .reg_wr_strb(reg_wr_strb),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .list_base_i(list_base_i),
    .idx_o(idx_o), .sof_o(sof_o), .list_addr_o(list_addr_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_state(string req);
    check(req, {18'b0, idx_o}, {18'b0, exp_idx});
    check(req, {21'b0, sof_o}, {21'b0, exp_sof});
    check(req, reg_rdata, {18'b0, exp_idx});
    check(req, list_addr_o, list_base_i + {20'b0, exp_idx[12:3], 2'b00});
  endtask

  // Inputs change 1 time unit after a rising edge, away from it.
  task automatic edge_step();
    @(posedge clk);
    #1;
  endtask

  task automatic tick(bit run, bit halt, bit model);
    run_i = run; halted_i = halt; uf_tick = 1'b1;
    edge_step();
    uf_tick = 1'b0;
    if (model) begin
      if (exp_idx[2:0] == 3'b000) exp_sof = exp_sof + 1'b1;
      exp_idx = exp_idx + 1'b1;
    end
  endtask

  task automatic reg_write(logic [31:0] d, logic [3:0] s, bit halt, bit model);
    halted_i = halt; run_i = !halt;
    reg_wr_en = 1'b1; reg_wr_strb = s; reg_wdata = d;
    edge_step();
    reg_wr_en = 1'b0; reg_wr_strb = 4'h0;
    if (model) begin
      exp_idx = d[13:0];
      exp_sof = d[13:3];
    end
  endtask

  task automatic t_reset();
    check_state("R1 reset");
    check("R1 rdata zero", reg_rdata, 32'h0);
  endtask

  task automatic t_advance();
    for (int i = 0; i < 20; i++) begin
      tick(1'b1, 1'b0, 1'b1);
      check_state("R3/R4/R5 advance");
    end
  endtask

  task automatic t_gating();
    tick(1'b0, 1'b0, 1'b0);
    check_state("R3 run low");
    tick(1'b1, 1'b1, 1'b0);
    check_state("R3 halted");
    run_i = 1'b1; halted_i = 1'b0;
    edge_step(); edge_step();
    check_state("R3 no tick");
  endtask

  task automatic t_write();
    reg_write(32'hFFFF_2ABD, 4'hF, 1'b1, 1'b1);
    check_state("R6 load");
    check("R2 upper zero", {18'b0, reg_rdata[31:14]}, 32'h0);
    check("R6 sof value", {21'b0, sof_o}, 32'h557);
  endtask

  task automatic t_write_running();
    reg_write(32'h0000_1111, 4'hF, 1'b0, 1'b0);
    check_state("R7 write while running");
  endtask

  task automatic t_partial();
    reg_write(32'h0000_0333, 4'h7, 1'b1, 1'b0);
    check_state("R8 strobe 0111");
    reg_write(32'h0000_0333, 4'h1, 1'b1, 1'b0);
    check_state("R8 strobe 0001");
  endtask

  task automatic t_odd_low();
    reg_write(32'h0000_0017, 4'hF, 1'b1, 1'b1);
    check_state("R9 load 111");
    tick(1'b1, 1'b0, 1'b1);
    check("R9 no step after 111", {21'b0, sof_o}, 32'h2);
    check_state("R9 after 111");
    reg_write(32'h0000_0020, 4'hF, 1'b1, 1'b1);
    tick(1'b1, 1'b0, 1'b1);
    check("R9 step after 000", {21'b0, sof_o}, 32'h5);
    check_state("R9 after 000");
  endtask

  task automatic t_wrap();
    reg_write(32'h0000_3FFD, 4'hF, 1'b1, 1'b1);
    check_state("R10 preload");
    for (int i = 0; i < 4; i++) begin
      tick(1'b1, 1'b0, 1'b1);
      check_state("R10 wrap");
    end
    check("R10 idx wrapped", {18'b0, idx_o}, 32'h1);
    check("R10 sof wrapped", {21'b0, sof_o}, 32'h0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*2 + 1);
    t_reset();
    rst_n = 1'b1;
    edge_step();
    t_reset();
    t_advance();
    t_gating();
    t_write();
    t_write_running();
    t_partial();
    t_odd_low();
    t_wrap();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule